// File: doc/BRIEF.md
# Multicycle Fixed-Point Quadratic Evaluator

This block evaluates y = A·x² + B·x + C on one unsigned fixed-point sample at a time. The input uses 4 integer and 12 fractional bits, which covers the working range 0 to 10. The constants are A = -0.0088, B = 1.7673 and C = 131.29. Each constant is stored with its own number of fractional bits, so that as much of its precision as possible is kept. The calculation is spread over a fixed sequence of five clock edges. The squaring and the two products are registered in separate stages, and the wide intermediate products are kept whole until the alignment stage.

A one-cycle `start` while the block is idle captures `x_in`. The block then forms x² and B·x, multiplies x² by A, and rounds each product onto the 8-fractional-bit grid of C. In the last stage it adds the two terms to C. The sum is held in a signed accumulator wider than the output and is clamped into the unsigned 16-bit output range. `done` pulses for one cycle when the new `result` appears, and `result` then holds until the next pulse. While a calculation runs, `busy` is high and further `start` pulses are dropped.

Top module: `quad_eval`

## Requirements
- R1: After reset `busy` and `done` are 0 and `result` is 0.
- R2: A `start` sampled high while `busy` is low is accepted. `done` is then high for exactly one cycle, right after the fifth rising edge counted from the edge that sampled `start` (that edge is the first).
- R3: `busy` is high in the four cycles after an accepted start and low in the cycle where `done` is high. A new start is accepted from that cycle on.
- R4: A `start` sampled while `busy` is high is ignored. No extra `done` pulse follows, and the `result` of the ongoing calculation is unchanged.
- R5: For inputs 0 to 10 (codes 0 to 40960, x = code/4096), `result` read as code/256 is within 2 LSB of A·x² + B·x + C rounded to the nearest multiple of 1/256.
- R6: An input code of 0 yields exactly 33610 (C stored with 8 fractional bits).
- R7: `result` does not change in any cycle in which `done` is low.
- R8: Input codes above 40960, up to 65535, still give a `result` within 2 LSB of the rounded formula. The sum is clamped to the range 0 to 65535 and is never wrapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to evaluate `x_in`; taken only when idle |
| x_in | input | 16 | Unsigned sample, 12 fractional bits |
| busy | output | 1 | A calculation is in flight |
| done | output | 1 | One-cycle pulse: `result` has just been updated |
| result | output | 16 | Unsigned value with 8 fractional bits |

## Verification
The assertions assume that `start` is a clean synchronous level and that `result` matters only at or after a `done` pulse. They place no limit on how often `start` is raised. The stimulus changes `start` and `x_in` only on falling edges. It issues single-cycle starts, and it deliberately raises `start` again in the middle of a calculation. It also issues a start in the same cycle that `done` pulses, to check that a start is accepted there. Because the arithmetic must stay in range for any 16-bit code, the stimulus covers the whole code space: the full valid range, the exact upper bound and the all-ones code.

// File: rtl/quad_eval_pkg.sv
package quad_eval_pkg;

  // number of register stages from capture to result
  localparam int unsigned QE_STAGES = 5;

  // fixed-point formats (fractional bit counts)
  localparam int unsigned QE_X_FRAC = 12;
  localparam int unsigned QE_A_FRAC = 21;
  localparam int unsigned QE_B_FRAC = 14;
  localparam int unsigned QE_Y_FRAC = 8;

  // quantised coefficients
  localparam int QE_A_CODE = -18455;
  localparam int QE_B_CODE = 28955;
  localparam int QE_C_CODE = 33610;

  // arithmetic right shift with round-half-up onto the coarser grid
  function automatic logic signed [63:0] round_shift(input logic signed [63:0] v,
                                                     input int unsigned sh);
    logic signed [63:0] half;
    half = (sh == 0) ? 64'sd0 : (64'sd1 <<< (sh - 1));
    return (v + half) >>> sh;
  endfunction

  // clamp a signed value into [0, 2^w - 1]
  function automatic logic [63:0] sat_unsigned(input logic signed [63:0] v,
                                               input int unsigned w);
    logic signed [63:0] top;
    top = (64'sd1 <<< w) - 64'sd1;
    if (v < 0)   return 64'd0;
    if (v > top) return 64'(top);
    return 64'(v);
  endfunction

endpackage

// File: rtl/quad_eval_ctrl.sv
module quad_eval_ctrl #(
  parameter int unsigned STAGES = quad_eval_pkg::QE_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  output logic [STAGES-1:0] stage_en,
  output logic              busy,
  output logic              done
);
  logic [STAGES-1:0] stage_v;

  assign busy   = |stage_v[STAGES-2:0];
  assign accept = start & ~busy;
  assign done   = stage_v[STAGES-1];

  // stage_en[0] loads x; stage_en[k] advances stage k
  assign stage_en = {stage_v[STAGES-2:0], accept};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_v <= '0;
    else        stage_v <= stage_en;
  end
endmodule

// File: rtl/quad_eval_dp.sv
module quad_eval_dp
  import quad_eval_pkg::*;
#(
  parameter int unsigned XW     = 16,
  parameter int unsigned KW     = 16,
  parameter int unsigned YW     = 16,
  parameter int unsigned STAGES = QE_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] stage_en,
  input  logic [XW-1:0]     x_in,
  output logic [YW-1:0]     y
);
  localparam int unsigned SQW  = 2 * XW;
  localparam int unsigned AXW  = KW + SQW + 1;
  localparam int unsigned BXW  = KW + XW + 1;
  localparam int unsigned SW   = YW + 4;
  localparam int unsigned A_SH = QE_A_FRAC + 2 * QE_X_FRAC - QE_Y_FRAC;
  localparam int unsigned B_SH = QE_B_FRAC + QE_X_FRAC - QE_Y_FRAC;

  localparam logic signed [KW-1:0] AK = KW'(QE_A_CODE);
  localparam logic signed [KW-1:0] BK = KW'(QE_B_CODE);
  localparam logic        [KW-1:0] CK = KW'(QE_C_CODE);

  logic        [XW-1:0]  x_q;
  logic        [SQW-1:0] sq_q;
  logic signed [BXW-1:0] bx_q;
  logic signed [AXW-1:0] ax_q;
  logic signed [SW-1:0]  at_q, bt_q;
  logic signed [SW-1:0]  sum_c;

  assign sum_c = at_q + bt_q + SW'($signed({1'b0, CK}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      sq_q <= '0;
      bx_q <= '0;
      ax_q <= '0;
      at_q <= '0;
      bt_q <= '0;
      y    <= '0;
    end else begin
      if (stage_en[0]) x_q <= x_in;
      if (stage_en[1]) begin
        sq_q <= SQW'(x_q) * SQW'(x_q);
        bx_q <= BXW'(BK) * $signed({{(BXW-XW){1'b0}}, x_q});
      end
      if (stage_en[2]) ax_q <= AXW'(AK) * $signed({{(AXW-SQW){1'b0}}, sq_q});
      if (stage_en[3]) begin
        at_q <= SW'(round_shift(64'(ax_q), A_SH));
        bt_q <= SW'(round_shift(64'(bx_q), B_SH));
      end
      if (stage_en[4]) y <= YW'(sat_unsigned(64'(sum_c), YW));
    end
  end
endmodule

// File: rtl/quad_eval.sv
module quad_eval #(
  parameter int unsigned XW = 16,
  parameter int unsigned KW = 16,
  parameter int unsigned YW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] x_in,
  output logic          busy,
  output logic          done,
  output logic [YW-1:0] result
);
  localparam int unsigned STAGES = quad_eval_pkg::QE_STAGES;

  logic              accept;
  logic [STAGES-1:0] stage_en;

  quad_eval_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .stage_en(stage_en), .busy(busy), .done(done)
  );

  quad_eval_dp #(.XW(XW), .KW(KW), .YW(YW), .STAGES(STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .x_in(x_in), .y(result)
  );
endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk #(
  parameter int unsigned YW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          busy,
  input logic          done,
  input logic [YW-1:0] result
);
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##5 done); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R3
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R7
endmodule

bind quad_eval quad_eval_chk #(.YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
  .done(done), .result(result)
);

// File: tb/quad_eval_test.sv
module quad_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] x_in = '0;
  logic        busy, done;
  logic [15:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  quad_eval uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .busy(busy), .done(done), .result(result)
  );

  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'd0, 16'd1, 16'd2048, 16'd4096, 16'd10000, 16'd16384,
    16'd20480, 16'd28672, 16'd32768, 16'd36864, 16'd40959, 16'd40960
  };

  function automatic int model(input logic [15:0] code);
    real v, y;
    v = real'(code) / 4096.0;
    y = (-0.0088 * v * v) + (1.7673 * v) + 131.29;
    return $rtoi(y * 256.0 + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b <= 2) && (b - a <= 2);
  endfunction

  // issue one start and follow the whole sequence; returns result at done
  task automatic run_one(input logic [15:0] code, input string req, output int got);
    @(negedge clk);
    x_in = code; start = 1'b1;
    @(negedge clk);               // edge 1 passed
    start = 1'b0;
    check(busy === 1'b1, "R3", int'(busy), 1);
    check(done === 1'b0, "R2", int'(done), 0);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b1, "R2", int'({busy, done}), 2);
    end
    @(negedge clk);               // edge 5 passed
    check(done === 1'b1, "R2", int'(done), 1);
    check(busy === 1'b0, "R3", int'(busy), 0);
    got = int'(result);
    check(near(got, model(code)), req, got, model(code));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int got, first;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0, "R1", int'({busy, done}), 0);
    check(result === 16'd0, "R1", int'(result), 0);
    rst_n = 1'b1;

    // R5: sweep of the valid range
    foreach (VEC[i]) begin
      run_one(VEC[i], "R5", got);
      @(negedge clk);
      check(done === 1'b0, "R2", int'(done), 0);
    end

    // R6: zero input exact
    run_one(16'd0, "R6", got);
    check(got == 33610, "R6", got, 33610);

    // R8: beyond the range
    run_one(16'd65535, "R8", got);
    run_one(16'd50000, "R8", got);

    // R4: start while busy is ignored
    @(negedge clk);
    x_in = 16'd40960; start = 1'b1;
    @(negedge clk);
    x_in = 16'd0;                 // still high: edge 2, busy
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);    // edge 5 passed
    check(done === 1'b1, "R4", int'(done), 1);
    first = int'(result);
    check(near(first, model(16'd40960)), "R4", first, model(16'd40960));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(done === 1'b0, "R4", int'(done), 0);
    end
    check(int'(result) == first, "R4", int'(result), first);

    // R7: result holds while inputs move and no start is given
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      x_in = 16'(k * 7000);
      check(int'(result) == first, "R7", int'(result), first);
    end

    // R3: start in the done cycle is accepted
    run_one(16'd4096, "R5", got);
    x_in = 16'd8192; start = 1'b1;   // done is high in this cycle
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R3", int'(busy), 1);
    repeat (4) @(negedge clk);
    check(done === 1'b1, "R3", int'(done), 1);
    check(near(int'(result), model(16'd8192)), "R5", int'(result), model(16'd8192));

    // R1: reset in the middle of a calculation
    @(negedge clk);
    x_in = 16'd30000; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && result === 16'd0, "R1",
          int'(result), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(done === 1'b0, "R1", int'(done), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule